// File: doc/BRIEF.md
# DMA Channel Address Generator

This block holds one address of a DMA channel and works out the address for the next bus beat each time a transfer completes. A channel uses two copies of it, one for the read side and one for the write side. Each copy is given the element size code, two update control bits and a ring setting, and it keeps its own address register.

Four update behaviours come from the two control bits. The address can stay fixed, step up by one element, step up by two elements, or step down by one element. A ring setting can also wrap the address inside a naturally aligned power-of-two window. When the ring is on, only the low address bits change and the bits above them stay as they are. A load strobe writes a new base address and wins over an update in the same cycle. Moving data, driving the bus, counting transfers and swapping bytes belong to other blocks.

Top module: `dma_addr_gen`

## Requirements
- R1: The step in bytes depends on `size_i`: code 0 gives 1, code 1 gives 2, code 2 gives 4. Code 3 gives 4, the same as code 2.
- R2: With `incr_i`=0 and `rev_i`=0 (mode 0), a `done_i` pulse leaves `addr_o` unchanged.
- R3: With `incr_i`=1 and `rev_i`=0 (mode 1), a `done_i` pulse adds one step to `addr_o` on the next clock.
- R4: With `incr_i`=0 and `rev_i`=1 (mode 2), a `done_i` pulse adds two steps to `addr_o`.
- R5: With `incr_i`=1 and `rev_i`=1 (mode 3), a `done_i` pulse subtracts one step from `addr_o`. Without a ring, all address arithmetic wraps modulo 2^AW.
- R6: When `ring_here_i`=1 and `ring_bits_i`=N with N nonzero, an update changes only the low N address bits: next = (cur & ~mask) | (computed & mask), where mask = 2^N-1. This holds in every mode, so a decrement below the ring base lands at the top of the ring.
- R7: When `ring_bits_i`=0 or `ring_here_i`=0, no wrapping is applied.
- R8: When `load_i`=1, `addr_o` takes `load_addr_i` on the next clock, whatever the value of `done_i`.
- R9: When `rst_ni` is low, `addr_o` is 0 at once, without waiting for a clock.
- R10: When neither `load_i` nor `done_i` is high, `addr_o` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| load_i | input | 1 | Load strobe for a new base address |
| load_addr_i | input | AW | Base address to load |
| done_i | input | 1 | One-cycle pulse marking a completed transfer |
| size_i | input | 2 | Element size code |
| incr_i | input | 1 | Increment enable, the low bit of the update mode |
| rev_i | input | 1 | Modifier, the high bit of the update mode |
| ring_bits_i | input | RBW | Ring size N; 0 means no ring |
| ring_here_i | input | 1 | The ring applies to this side of the channel |
| addr_o | output | AW | Current address, used for the next beat |

## Verification
The bench builds the block with the default values AW=32 and RBW=5. With these values every ring size from 1 to 31 can be set, and the 32-bit arithmetic wrap at both the top and the bottom of the address space can be reached without a ring. Directed cases cover each size code, each mode, ring wrap in both directions, a load together with `done_i`, and a reset in the middle of a run. A long stretch of mixed random stimulus then checks the output against the reference model on every clock.

// File: rtl/dma_agen_pkg.sv
package dma_agen_pkg;
  typedef enum logic [1:0] {
    UPD_FIXED = 2'd0,
    UPD_INC   = 2'd1,
    UPD_DBL   = 2'd2,
    UPD_DEC   = 2'd3
  } upd_mode_e;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_RSVD = 2'd3
  } elem_size_e;
endpackage

// File: rtl/dma_agen_step.sv
module dma_agen_step
  import dma_agen_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic [AW-1:0] cur_i,
  input  logic [1:0]    size_i,
  input  logic          incr_i,
  input  logic          rev_i,
  output logic [AW-1:0] sum_o
);
  elem_size_e    sz;
  upd_mode_e     mode;
  logic [AW-1:0] step;
  logic [AW-1:0] delta;

  always_comb begin
    sz = elem_size_e'(size_i);
    if (sz == SZ_RSVD) sz = SZ_WORD;
    step = AW'(1) << sz;
  end

  assign mode = upd_mode_e'({rev_i, incr_i});

  always_comb begin
    unique case (mode)
      UPD_FIXED: delta = '0;
      UPD_INC:   delta = step;
      UPD_DBL:   delta = step << 1;
      UPD_DEC:   delta = AW'(0) - step;
      default:   delta = '0;
    endcase
  end

  assign sum_o = cur_i + delta;
endmodule

// File: rtl/dma_agen_ring.sv
module dma_agen_ring #(
  parameter int AW  = 32,
  parameter int RBW = 5
) (
  input  logic [AW-1:0]  cur_i,
  input  logic [AW-1:0]  sum_i,
  input  logic [RBW-1:0] ring_bits_i,
  input  logic           ring_here_i,
  output logic [AW-1:0]  next_o
);
  logic [AW-1:0] mask;
  logic          ring_on;

  assign ring_on = ring_here_i && (ring_bits_i != '0);

  // per-bit mask: bit i moves when it lies below the ring size
  for (genvar i = 0; i < AW; i++) begin : g_mask
    assign mask[i] = !ring_on || (32'(ring_bits_i) > 32'(i));
  end

  assign next_o = (cur_i & ~mask) | (sum_i & mask);
endmodule

// File: rtl/dma_addr_gen.sv
module dma_addr_gen #(
  parameter int AW  = 32,
  parameter int RBW = 5
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           load_i,
  input  logic [AW-1:0]  load_addr_i,
  input  logic           done_i,
  input  logic [1:0]     size_i,
  input  logic           incr_i,
  input  logic           rev_i,
  input  logic [RBW-1:0] ring_bits_i,
  input  logic           ring_here_i,
  output logic [AW-1:0]  addr_o
);
  logic [AW-1:0] addr_q;
  logic [AW-1:0] sum;
  logic [AW-1:0] next;

  dma_agen_step #(.AW(AW)) u_step (
    .cur_i  (addr_q),
    .size_i (size_i),
    .incr_i (incr_i),
    .rev_i  (rev_i),
    .sum_o  (sum)
  );

  dma_agen_ring #(.AW(AW), .RBW(RBW)) u_ring (
    .cur_i       (addr_q),
    .sum_i       (sum),
    .ring_bits_i (ring_bits_i),
    .ring_here_i (ring_here_i),
    .next_o      (next)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     addr_q <= '0;
    else if (load_i) addr_q <= load_addr_i;
    else if (done_i) addr_q <= next;
  end

  assign addr_o = addr_q;

  logic upd;
  logic no_ring;
  logic [AW-1:0] step_chk;
  assign upd      = done_i && !load_i;
  assign no_ring  = !ring_here_i || (ring_bits_i == '0);
  assign step_chk = AW'(1) << ((size_i == 2'd3) ? 2'd2 : size_i);

  p_load_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> addr_o == $past(load_addr_i));
  p_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && !done_i) |=> $stable(addr_o));
  p_fixed_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd && !incr_i && !rev_i) |=> $stable(addr_o));
  p_inc_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd && incr_i && !rev_i && no_ring) |=> addr_o == $past(addr_o) + $past(step_chk));
  p_dec_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd && incr_i && rev_i && no_ring) |=> addr_o == $past(addr_o) - $past(step_chk));
  p_upper_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd && !no_ring) |=> ((addr_o ^ $past(addr_o)) >> $past(ring_bits_i)) == '0);
endmodule

// File: tb/sim_dma_addr_gen.sv
module sim_dma_addr_gen;
  localparam int AW = 32;
  localparam int RBW = 5;
  localparam int CLK_PERIOD = 10;

  logic clk = 0;
  logic rst_n = 0;
  logic load = 0;
  logic [AW-1:0] load_addr = '0;
  logic done = 0;
  logic [1:0] size = '0;
  logic incr = 0, rev = 0;
  logic [RBW-1:0] ring_bits = '0;
  logic ring_here = 0;
  logic [AW-1:0] addr;

  int checks = 0;
  int fails = 0;
  logic [AW-1:0] exp_addr = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dma_addr_gen #(.AW(AW), .RBW(RBW)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .load_i(load), .load_addr_i(load_addr),
    .done_i(done), .size_i(size), .incr_i(incr), .rev_i(rev),
    .ring_bits_i(ring_bits), .ring_here_i(ring_here), .addr_o(addr)
  );

  task automatic check(input string tag, input logic [AW-1:0] exp);
    checks++;
    if (addr !== exp) begin
      fails++;
      $display("FAIL %s: addr=%h expected=%h", tag, addr, exp);
    end
  endtask

  function automatic logic [AW-1:0] model(input logic [AW-1:0] cur);
    longint unsigned stp, c, m;
    int n;
    stp = 64'd1 << ((size == 2'd3) ? 2 : int'(size));
    case ({rev, incr})
      2'b00: c = cur;
      2'b01: c = cur + stp;
      2'b10: c = cur + 2 * stp;
      default: c = cur - stp;
    endcase
    n = int'(ring_bits);
    if (ring_here && n != 0) m = (64'd1 << n) - 1;
    else m = 64'hFFFF_FFFF;
    return AW'((longint'(cur) & ~m) | (c & m));
  endfunction

  // called at a negedge: apply inputs, predict, check at next negedge
  task automatic cyc(input string tag, input logic ld, input logic [AW-1:0] la,
                     input logic dn, input logic [1:0] sz, input logic inc,
                     input logic rv, input logic [RBW-1:0] rb, input logic rh);
    load = ld; load_addr = la; done = dn; size = sz; incr = inc; rev = rv;
    ring_bits = rb; ring_here = rh;
    if (ld) exp_addr = la;
    else if (dn) exp_addr = model(exp_addr);
    @(negedge clk);
    check(tag, exp_addr);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R9 reset", '0);
    rst_n = 1;
    @(negedge clk);
    cyc("R8 load", 1, 32'h1000, 0, 0, 0, 0, 0, 0);
    cyc("R2 fixed", 0, 0, 1, 2, 0, 0, 0, 0);
    cyc("R10 idle", 0, 0, 0, 2, 1, 0, 0, 0);
    cyc("R1 R3 inc byte", 0, 0, 1, 0, 1, 0, 0, 0);
    cyc("R1 R3 inc half", 0, 0, 1, 1, 1, 0, 0, 0);
    cyc("R1 R3 inc word", 0, 0, 1, 2, 1, 0, 0, 0);
    cyc("R1 code3 inc", 0, 0, 1, 3, 1, 0, 0, 0);
    cyc("R4 double half", 0, 0, 1, 1, 0, 1, 0, 0);
    cyc("R4 double word", 0, 0, 1, 2, 0, 1, 0, 0);
    cyc("R5 dec byte", 0, 0, 1, 0, 1, 1, 0, 0);
    cyc("R8 load", 1, 32'h0, 0, 0, 0, 0, 0, 0);
    cyc("R5 dec underflow", 0, 0, 1, 2, 1, 1, 0, 0);
    cyc("R5 wrap top", 0, 0, 1, 2, 1, 0, 0, 0);
    cyc("R8 load", 1, 32'h2000, 0, 0, 0, 0, 0, 0);
    cyc("R6 ring dec under", 0, 0, 1, 2, 1, 1, 4, 1);
    if (exp_addr !== 32'h200C) begin fails++; $display("FAIL R6 model exp=%h", exp_addr); end
    cyc("R8 load", 1, 32'h201C, 0, 0, 0, 0, 0, 0);
    cyc("R6 ring inc wrap", 0, 0, 1, 2, 1, 0, 5, 1);
    cyc("R6 ring double", 0, 0, 1, 2, 0, 1, 3, 1);
    cyc("R8 load", 1, 32'h201C, 0, 0, 0, 0, 0, 0);
    cyc("R7 ring other side", 0, 0, 1, 2, 1, 0, 5, 0);
    cyc("R7 ring size zero", 0, 0, 1, 2, 1, 0, 0, 1);
    cyc("R8 load beats done", 1, 32'hABCD0000, 1, 2, 1, 0, 0, 0);
    for (int i = 0; i < 3000; i++) begin
      logic ld, dn;
      ld = ($urandom_range(0, 15) == 0);
      dn = ($urandom_range(0, 3) != 0);
      cyc("R3 R6 random", ld, $urandom(), dn, 2'($urandom_range(0, 3)),
          1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
          RBW'($urandom_range(0, 31)), 1'($urandom_range(0, 1)));
    end
    load = 0; done = 0;
    #2 rst_n = 0;
    #1 check("R9 async reset", '0);
    exp_addr = '0;
    @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R9 after reset", '0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: addr=%h expected=finish", addr);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule